// File: doc/BRIEF.md
# Multi-Timer Event Timer Register Block

This block is a memory-mapped event timer. It has one 64-bit main counter and three comparator timers, and it sits behind a simple single-cycle 32-bit register bus. Software enables the block through a general configuration register. After that, the main counter advances once for every tick-enable pulse.

Each timer watches the counter. When the counter reaches the timer's comparator value, the timer latches a status bit and drives a one-cycle pulse on its own interrupt line. In periodic mode the timer then adds its period to the comparator, which re-arms it for the next match.

Writes to the 64-bit configuration registers are done through their low 32-bit half. Only the bits that the register marks as writable change, and the upper half is never altered. A timer can be switched to a 32-bit width. In that width its comparator and period lose their upper halves, and matching uses only the low 32 bits of the counter.

Top module: `event_timer_regs`

## Requirements
- R1: Reset values:
  - main counter = 0, general configuration = 0, interrupt status = 0;
  - every comparator = all ones, every period = 0;
  - each timer configuration low word reads 0x00000030 and its high word reads 0x00000004.
- R2: Address decode:
  - timer n (n = 0..2) occupies 0x100 + n*0x20; within that block, +0x00/+0x04 hold configuration low/high, +0x08/+0x0C comparator low/high, and +0x10/+0x14 period low/high;
  - any other address reads 0, and a write to it changes nothing.
- R3: General configuration at 0x010:
  - bit 0 is the global enable and bit 1 is the legacy-route flag; both are writable;
  - all other bits read 0;
  - the high word at 0x014 reads 0 and ignores writes.
- R4: Timer configuration write mask:
  - a write to the low word changes only bit 1 (level select), bit 2 (interrupt enable), bit 3 (periodic mode) and bit 8 (32-bit mode);
  - bits 4 (periodic capable) and 5 (64-bit capable) always read 1;
  - the high word always reads 0x00000004 and ignores writes.
- R5: Level select (timer configuration bit 1) is stored but has no effect: a match still yields a single edge pulse.
- R6: 32-bit mode (timer configuration bit 8):
  - any configuration write with bit 8 set clears the upper 32 bits of that timer's comparator and period;
  - while bit 8 is set, writes to those upper halves are ignored, matching uses only counter bits 31:0, and a periodic reload wraps at 32 bits.
- R7: Main counter:
  - it advances by one on each clock with tick high while the global enable is set, and otherwise holds;
  - it is written through 0x0F0 (low) and 0x0F4 (high).
- R8: A 0-to-1 change of the global enable starts counting from the counter's current value without resetting it. Writing 1 while the enable is already set changes nothing.
- R9: Capability/ID registers:
  - 0x000 reads 0x0F1EA201 (revision 1 in bits 7:0, timer count minus one in bits 12:8, 64-bit counter in bit 13, legacy routing capable in bit 15);
  - 0x004 reads the tick period parameter (default 0x00989680);
  - writes to either address are ignored.
- R10: Match and interrupt:
  - a match occurs when a tick moves the counter to a value equal to a timer's comparator while that timer's bit 2 and the global enable are set;
  - on a match, status bit n is set at that clock edge and `irq[n]` is high for the following cycle.
- R11: Periodic reload: on a match with timer configuration bit 3 set, the comparator becomes comparator + period.
- R12: Interrupt status at 0x020, bits 2:0, one bit per timer:
  - writing 1 to a bit clears it and writing 0 leaves it unchanged;
  - a match in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable, one count per cycle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the 32-bit register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 3 | One-cycle interrupt pulse per timer |

## Verification
The bench targets the upper half of the 64-bit configuration registers. A design that stores the whole written word there would lose the advertised route value 0x00000004 or let writes reach the read-only capability bits.

It arms a 32-bit-mode timer while the counter's upper word is nonzero. A design that compares all 64 bits never fires in that case, and one that forgets to truncate keeps stale comparator bits.

It runs a periodic timer through several reloads and checks the comparator that results. It also toggles the enable to prove that the counter resumes instead of restarting.

It writes status with zero and then with one, and writes the ID register. A design that clears on any write, or that accepts the ID write, is caught at the read port.

// File: rtl/event_timer_regs.sv
module event_timer_regs #(
  parameter logic [31:0] PERIOD_FS = 32'h0098_9680
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [2:0]  irq
);
  localparam int          NT      = 3;
  localparam logic [31:0] CAP_LO  = 32'h0F1E_A201;
  localparam logic [31:0] CFG_WM  = 32'h0000_010E;
  localparam logic [31:0] CFG_RST = 32'h0000_0030;
  localparam logic [31:0] CFG_HI  = 32'h0000_0004;
  localparam logic [11:0] TBASE   = 12'h100;
  localparam logic [11:0] TEND    = TBASE + 12'(NT * 32);

  logic [63:0]   cnt;
  logic [63:0]   cmp [NT];
  logic [63:0]   per [NT];
  logic [31:0]   tcfg [NT];
  logic [1:0]    gcfg;
  logic [NT-1:0] sts, fire;

  wire [63:0] cnt_nx = cnt + 64'd1;
  wire [11:0] toff   = addr - TBASE;
  wire        t_hit  = (addr >= TBASE) && (addr < TEND) && (addr[1:0] == 2'b00);
  wire [1:0]  tsel   = toff[6:5];
  wire [4:0]  treg   = toff[4:0];

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      fire[i] = tick && gcfg[0] && tcfg[i][2] &&
                (tcfg[i][8] ? (cnt_nx[31:0] == cmp[i][31:0]) : (cnt_nx == cmp[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      gcfg <= '0;
      sts  <= '0;
      irq  <= '0;
      for (int i = 0; i < NT; i++) begin
        cmp[i]  <= '1;
        per[i]  <= '0;
        tcfg[i] <= CFG_RST;
      end
    end else begin
      if (gcfg[0] && tick) cnt <= cnt_nx;
      for (int i = 0; i < NT; i++) begin
        if (fire[i]) begin
          sts[i] <= 1'b1;
          if (tcfg[i][3])
            cmp[i] <= tcfg[i][8] ? {32'h0, cmp[i][31:0] + per[i][31:0]} : cmp[i] + per[i];
        end
      end
      irq <= fire;
      if (wr_en) begin
        case (addr)
          12'h010: gcfg <= wdata[1:0];
          12'h020: sts <= (sts & ~wdata[NT-1:0]) | fire;
          12'h0F0: cnt[31:0] <= wdata;
          12'h0F4: cnt[63:32] <= wdata;
          default: ;
        endcase
        if (t_hit) begin
          case (treg)
            5'h00: begin
              tcfg[tsel] <= (tcfg[tsel] & ~CFG_WM) | (wdata & CFG_WM);
              if (wdata[8]) begin
                cmp[tsel][63:32] <= '0;
                per[tsel][63:32] <= '0;
              end
            end
            5'h08: cmp[tsel][31:0] <= wdata;
            5'h0C: if (!tcfg[tsel][8]) cmp[tsel][63:32] <= wdata;
            5'h10: per[tsel][31:0] <= wdata;
            5'h14: if (!tcfg[tsel][8]) per[tsel][63:32] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      12'h000: rdata = CAP_LO;
      12'h004: rdata = PERIOD_FS;
      12'h010: rdata = {30'h0, gcfg};
      12'h020: rdata = {{(32-NT){1'b0}}, sts};
      12'h0F0: rdata = cnt[31:0];
      12'h0F4: rdata = cnt[63:32];
      default: ;
    endcase
    if (t_hit) begin
      case (treg)
        5'h00: rdata = tcfg[tsel];
        5'h04: rdata = CFG_HI;
        5'h08: rdata = cmp[tsel][31:0];
        5'h0C: rdata = cmp[tsel][63:32];
        5'h10: rdata = per[tsel][31:0];
        5'h14: rdata = per[tsel][63:32];
        default: ;
      endcase
    end
  end

  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(gcfg[0]));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gcfg[0] && !(wr_en && (addr == 12'h0F0 || addr == 12'h0F4))) |=> (cnt == $past(cnt)));

  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcfg[0]) |-> (cnt == $past(cnt)));

  for (genvar g = 0; g < NT; g++) begin : g_chk
    p_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tcfg[g][8] |-> (cmp[g][63:32] == 32'h0 && per[g][63:32] == 32'h0));
    p_irq_sets_sts_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> sts[g]);
  end
endmodule

// File: tb/sim_event_timer_regs.sv
module sim_event_timer_regs;
  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0, errors = 0;
  int irq_seen [3];
  string tag = "R1";
  bit done = 0;

  event_timer_regs u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference
  logic [63:0] m_cnt, nx;
  logic [63:0] m_cmp [3];
  logic [63:0] m_per [3];
  logic [31:0] m_cfg [3];
  logic [1:0]  m_gen;
  logic [2:0]  m_sts, m_irq, f;

  function automatic logic [31:0] m_read(logic [11:0] a);
    int n, r;
    if (a >= 12'h100 && a < 12'h160 && a[1:0] == 0) begin
      n = (int'(a) - 256) / 32;
      r = (int'(a) - 256) % 32;
      case (r)
        0: return m_cfg[n] | 32'h30;
        4: return 32'h4;
        8: return m_cmp[n][31:0];
        12: return m_cmp[n][63:32];
        16: return m_per[n][31:0];
        20: return m_per[n][63:32];
        default: return 0;
      endcase
    end
    case (a)
      12'h000: return 32'h0F1EA201;
      12'h004: return 32'h00989680;
      12'h010: return {30'h0, m_gen};
      12'h020: return {29'h0, m_sts};
      12'h0F0: return m_cnt[31:0];
      12'h0F4: return m_cnt[63:32];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_gen = 0; m_sts = 0; m_irq = 0;
      for (int i = 0; i < 3; i++) begin
        m_cmp[i] = '1; m_per[i] = 0; m_cfg[i] = 0;
      end
    end else begin
      nx = m_cnt + 1;
      for (int i = 0; i < 3; i++)
        f[i] = tick && m_gen[0] && m_cfg[i][2] &&
               (m_cfg[i][8] ? nx[31:0] == m_cmp[i][31:0] : nx == m_cmp[i]);
      if (m_gen[0] && tick) m_cnt = nx;
      for (int i = 0; i < 3; i++)
        if (f[i]) begin
          m_sts[i] = 1;
          if (m_cfg[i][3]) begin
            m_cmp[i] = m_cmp[i] + m_per[i];
            if (m_cfg[i][8]) m_cmp[i][63:32] = 0;
          end
        end
      m_irq = f;
      if (wr_en) begin
        if (addr >= 12'h100 && addr < 12'h160 && addr[1:0] == 0) begin
          int n, r;
          n = (int'(addr) - 256) / 32;
          r = (int'(addr) - 256) % 32;
          case (r)
            0: begin
              m_cfg[n] = wdata & 32'h10E;
              if (wdata[8]) begin m_cmp[n][63:32] = 0; m_per[n][63:32] = 0; end
            end
            8: m_cmp[n][31:0] = wdata;
            12: if (!m_cfg[n][8]) m_cmp[n][63:32] = wdata;
            16: m_per[n][31:0] = wdata;
            20: if (!m_cfg[n][8]) m_per[n][63:32] = wdata;
            default: ;
          endcase
        end
        case (addr)
          12'h010: m_gen = wdata[1:0];
          12'h020: m_sts = (m_sts & ~wdata[2:0]) | f;
          12'h0F0: m_cnt[31:0] = wdata;
          12'h0F4: m_cnt[63:32] = wdata;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s irq act=%b exp=%b", tag, irq, m_irq);
      end
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL %s rdata@%h act=%h exp=%h", tag, addr, rdata, m_read(addr));
      end
      for (int i = 0; i < 3; i++) irq_seen[i] += int'(irq[i]);
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string t);
    @(negedge clk); addr = a; #1;
    chk(t, rdata, exp);
  endtask

  task automatic ticks(int k);
    @(negedge clk); tick = 1;
    repeat (k) @(negedge clk);
    tick = 0;
  endtask

  function automatic logic [11:0] ta(int n, int r);
    return 12'(256 + n * 32 + r);
  endfunction

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    rd(12'h010, 0, "R1 gcfg"); rd(12'h020, 0, "R1 sts");
    rd(12'h0F0, 0, "R1 cnt"); irq_seen = '{0, 0, 0};
    for (int n = 0; n < 3; n++) begin
      rd(ta(n, 0), 32'h30, "R1 tcfg lo"); rd(ta(n, 4), 32'h4, "R1 tcfg hi");
      rd(ta(n, 8), 32'hFFFFFFFF, "R1 cmp lo"); rd(ta(n, 12), 32'hFFFFFFFF, "R1 cmp hi");
      rd(ta(n, 16), 0, "R1 per lo");
    end
    tag = "R9";
    wr(12'h000, 0); wr(12'h004, 0);
    rd(12'h000, 32'h0F1EA201, "R9 cap"); rd(12'h004, 32'h00989680, "R9 period");
    tag = "R2";
    wr(12'h030, '1); wr(ta(0, 24), '1); wr(12'h160, '1);
    rd(12'h030, 0, "R2 unmapped"); rd(ta(0, 24), 0, "R2 gap"); rd(12'h160, 0, "R2 past end");
    wr(ta(1, 8), 32'h55);
    rd(ta(1, 8), 32'h55, "R2 t1 cmp"); rd(ta(0, 8), 32'hFFFFFFFF, "R2 t0 untouched");
    tag = "R3";
    wr(12'h010, '1); rd(12'h010, 3, "R3 gcfg mask");
    wr(12'h014, '1); rd(12'h014, 0, "R3 gcfg hi");
    wr(12'h010, 0); rd(12'h010, 0, "R3 gcfg clear");
    tag = "R4";
    wr(ta(2, 0), 32'hFFFFFEFF); rd(ta(2, 0), 32'h3E, "R4 tcfg mask");
    wr(ta(2, 4), 0); rd(ta(2, 4), 32'h4, "R4 tcfg hi");
    tag = "R6";
    wr(ta(2, 12), 32'h12345678); rd(ta(2, 12), 32'h12345678, "R6 cmp hi 64b");
    wr(ta(2, 20), 32'hAB);
    wr(ta(2, 0), 32'h100); rd(ta(2, 0), 32'h130, "R6 mode");
    rd(ta(2, 12), 0, "R6 cmp trunc"); rd(ta(2, 20), 0, "R6 per trunc");
    rd(ta(2, 8), 32'hFFFFFFFF, "R6 cmp lo kept");
    wr(ta(2, 12), 7); rd(ta(2, 12), 0, "R6 hi write ignored");
    wr(ta(2, 0), 0);
    tag = "R7";
    wr(12'h0F0, 32'h10); rd(12'h0F0, 32'h10, "R7 cnt write");
    wr(12'h010, 1); ticks(5); wr(12'h010, 0);
    rd(12'h0F0, 32'h15, "R7 count");
    ticks(3); rd(12'h0F0, 32'h15, "R7 hold");
    tag = "R8";
    wr(12'h010, 1); rd(12'h0F0, 32'h15, "R8 resume");
    wr(12'h010, 1); rd(12'h0F0, 32'h15, "R8 rewrite");
    ticks(2); rd(12'h0F0, 32'h17, "R8 continues");
    tag = "R10";
    wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(ta(0, 8), 5); wr(ta(0, 12), 0); wr(ta(0, 0), 6);
    wr(12'h010, 1); ticks(5); @(negedge clk);
    chk("R10 irq0 pulses", irq_seen[0], 1);
    rd(12'h020, 1, "R10 status");
    tag = "R5";
    ticks(5); @(negedge clk);
    chk("R5 single edge pulse", irq_seen[0], 1);
    tag = "R12";
    wr(12'h020, 0); rd(12'h020, 1, "R12 write 0 keeps");
    wr(12'h020, 1); rd(12'h020, 0, "R12 write 1 clears");
    tag = "R11";
    wr(12'h010, 0); wr(12'h0F0, 0);
    wr(ta(1, 8), 4); wr(ta(1, 12), 0); wr(ta(1, 16), 3); wr(ta(1, 0), 32'hC);
    wr(12'h010, 1); ticks(12); @(negedge clk);
    chk("R11 periodic pulses", irq_seen[1], 3);
    rd(ta(1, 8), 32'hD, "R11 reload");
    tag = "R6";
    wr(12'h010, 0); wr(ta(2, 8), 32'h20); wr(ta(2, 0), 32'h104);
    wr(12'h0F4, 1); wr(12'h0F0, 32'h1E);
    wr(12'h010, 1); ticks(3); @(negedge clk);
    chk("R6 low-word match", irq_seen[2], 1);
    rd(12'h0F4, 1, "R6 cnt hi");
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule